// File: doc/BRIEF.md
# Translation Cache with Persistent Global Entries

This block is a small fully associative cache of virtual-to-physical translations for 4 KB pages. The tag of each entry is a virtual page number, which is address bits 31 to 12. The entry holds the physical frame number and a 4-bit attribute field: writable, user, dirty and global. A lookup that a requester presents in one cycle gets its hit flag, frame and attributes from registers one cycle later, so a hit needs no walk through memory. A page walker outside the block writes new translations through the fill port.

Two commands remove entries. A translation-base write is issued on a context switch. It removes every entry whose global attribute is clear, and keeps the global entries while the global-enable input is high. When global-enable is low, it removes every entry. A single-page invalidate removes only the entry whose tag equals the given page, global or not.

A fill replaces the lowest-numbered free slot when the cache has one. When the cache is full, a round-robin pointer picks the slot. A fill for a page that is already cached overwrites that entry in place, so no tag is ever stored twice.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, and `lk_hit`, `lk_pfn` and `lk_attr` are 0.
- R2: A lookup presented in cycle N reports, in cycle N+1, `lk_hit`=1 with the stored frame and attributes when the page is cached. Otherwise it reports `lk_hit`=0, `lk_pfn`=0 and `lk_attr`=0. The attribute encoding is bit0 writable, bit1 user, bit2 dirty, bit3 global.
- R3: A fill in cycle N is visible to lookups from cycle N+1. A lookup of the same page in cycle N misses.
- R4: A fill for a page that is already cached replaces that entry's frame and attributes in place and evicts nothing.
- R5: A fill uses the lowest-numbered free slot when one exists. In a full cache, a round-robin pointer picks the victim. The pointer starts at slot 0 after reset and advances by one on each such eviction.
- R6: A base write with `glob_en`=1 removes every entry whose attribute bit3 is 0 and keeps every entry whose attribute bit3 is 1.
- R7: A base write with `glob_en`=0 removes every entry.
- R8: A single-page invalidate removes only the entry whose tag equals `inv_vpn`, even when that entry is global, and leaves all other entries intact.
- R9: A base write or single-page invalidate in the same cycle as a lookup acts first, so the lookup of an affected page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to look up |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_pfn | output | 20 | Frame of the hit entry, 0 on a miss |
| lk_attr | output | 4 | Attributes of the hit entry, 0 on a miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_pfn | input | 20 | Frame of the fill |
| fill_attr | input | 4 | Attributes of the fill |
| base_wr | input | 1 | Translation-base write (context-switch flush) |
| glob_en | input | 1 | Keep global entries across a base write |
| inv_pg | input | 1 | Single-page invalidate |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
The assertions check, on every cycle, four properties:
- A hit always follows a lookup request.
- No lookup ever matches two entries.
- A lookup that meets a full flush misses.
- A lookup that meets an invalidate of its own page misses.

Only the bench scenarios can show which entries survive a flush. The same holds for the correct frames and attributes, the in-place overwrite and the order of victim selection. The bench shows these by filling the whole cache, sweeping lookups over every entry after each command, and comparing against values computed from the page numbers.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [3:0]       lk_attr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [3:0]       fill_attr,
  input  logic             base_wr,
  input  logic             glob_en,
  input  logic             inv_pg,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int GBIT = 3;

  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [PFN_W-1:0] pfn_q  [ENTRIES];
  logic [3:0]       attr_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, kill, live, hv, fm;
  logic [IW-1:0] rr_q, victim;
  logic in_place, free_slot;
  logic [PFN_W-1:0] pfn_n;
  logic [3:0] attr_n;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      kill[i] = valid_q[i] &
                ((base_wr & ~(glob_en & attr_q[i][GBIT])) |
                 (inv_pg & (tag_q[i] == inv_vpn)));
      hv[i]   = lk_valid & valid_q[i] & ~kill[i] & (tag_q[i] == lk_vpn);
      fm[i]   = valid_q[i] & (tag_q[i] == fill_vpn);
    end
  end

  assign live = valid_q & ~kill;

  always_comb begin
    victim    = rr_q;
    free_slot = 1'b0;
    in_place  = |fm;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!live[i]) begin
        victim    = IW'(i);
        free_slot = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (fm[i]) victim = IW'(i);
  end

  always_comb begin
    pfn_n  = '0;
    attr_n = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hv[i]) begin
        pfn_n  = pfn_n | pfn_q[i];
        attr_n = attr_n | attr_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      lk_hit  <= 1'b0;
      lk_pfn  <= '0;
      lk_attr <= '0;
    end else begin
      lk_hit  <= |hv;
      lk_pfn  <= pfn_n;
      lk_attr <= attr_n;
      valid_q <= live;
      if (fill_en) begin
        valid_q[victim] <= 1'b1;
        tag_q[victim]   <= fill_vpn;
        pfn_q[victim]   <= fill_pfn;
        attr_q[victim]  <= fill_attr;
        if (!in_place && !free_slot)
          rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end
endmodule

module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic               base_wr,
  input logic               glob_en,
  input logic               inv_pg,
  input logic [VPN_W-1:0]   inv_vpn,
  input logic [ENTRIES-1:0] hv
);
  a_r2_hit_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));
  a_r7_full_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && base_wr && !glob_en) |=> !lk_hit);
  a_r9_inv_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && inv_pg && lk_vpn == inv_vpn) |=> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .base_wr(base_wr), .glob_en(glob_en), .inv_pg(inv_pg),
  .inv_vpn(inv_vpn), .hv(hv)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, base_wr = 0, glob_en = 0, inv_pg = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0, fill_pfn = 0;
  logic [3:0] fill_attr = 0;
  logic lk_hit;
  logic [19:0] lk_pfn;
  logic [3:0] lk_attr;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  function automatic logic [19:0] va(int i);  return 20'(i * 32'h111 + 3); endfunction
  function automatic logic [19:0] pa(int i);  return va(i) ^ 20'h5A5A5; endfunction
  function automatic logic [19:0] wa(int i);  return 20'(32'h80000 + i * 7); endfunction
  function automatic logic [3:0]  at(int i);  return 4'(i); endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check(bit ok, string req, logic [27:0] act, logic [27:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic [3:0] a);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_attr = a;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic expect_out(bit eh, logic [19:0] ep, logic [3:0] ea, string req);
    logic [19:0] xp = eh ? ep : 20'h0;
    logic [3:0]  xa = eh ? ea : 4'h0;
    check(lk_hit == eh && lk_pfn == xp && lk_attr == xa, req,
          {3'b0, lk_hit, lk_attr, lk_pfn}, {3'b0, eh, xa, xp});
  endtask

  task automatic look(logic [19:0] v, bit eh, logic [19:0] ep, logic [3:0] ea, string req);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 0;
    expect_out(eh, ep, ea, req);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_out(0, 0, 0, "R1 reset outputs");
    look(va(0), 0, 0, 0, "R1 empty after reset");

    for (int i = 0; i < N; i++) fill(va(i), pa(i), at(i));
    for (int i = 0; i < N; i++) look(va(i), 1, pa(i), at(i), "R2 hit sweep");
    look(20'hFFFFF, 0, 0, 0, "R2 miss uncached page");

    fill(va(3), 20'h12345, 4'h7);
    look(va(3), 1, 20'h12345, 4'h7, "R4 overwrite in place");
    for (int i = 0; i < N; i++)
      if (i != 3) look(va(i), 1, pa(i), at(i), "R4 nothing evicted");

    fill(wa(0), 20'h00AAA, 4'h0);
    look(va(0), 0, 0, 0, "R5 round robin evicts slot 0");
    look(wa(0), 1, 20'h00AAA, 4'h0, "R5 new entry present");
    fill(wa(1), 20'h00BBB, 4'h0);
    look(va(1), 0, 0, 0, "R5 round robin evicts slot 1");
    look(va(2), 1, pa(2), at(2), "R5 slot 2 kept");

    @(negedge clk); base_wr = 1; glob_en = 1;
    @(negedge clk); base_wr = 0;
    for (int i = 2; i < N; i++)
      if (i != 3) look(va(i), i >= 8, pa(i), at(i), "R6 global entries survive");
    look(va(3), 0, 0, 0, "R6 non-global removed");
    look(wa(0), 0, 0, 0, "R6 non-global removed");

    @(negedge clk); inv_pg = 1; inv_vpn = va(9);
    @(negedge clk); inv_pg = 0;
    look(va(9), 0, 0, 0, "R8 global page invalidated");
    for (int i = 8; i < N; i++)
      if (i != 9) look(va(i), 1, pa(i), at(i), "R8 other entries intact");

    for (int j = 0; j < 9; j++) fill(wa(j + 4), 20'(j + 100), 4'h1);
    for (int j = 0; j < 9; j++) look(wa(j + 4), 1, 20'(j + 100), 4'h1, "R5 free slots used");
    for (int i = 8; i < N; i++)
      if (i != 9) look(va(i), 1, pa(i), at(i), "R5 free slots preferred");

    @(negedge clk); base_wr = 1; glob_en = 0;
    @(negedge clk); base_wr = 0;
    for (int i = 8; i < N; i++) look(va(i), 0, 0, 0, "R7 all flushed");
    look(wa(4), 0, 0, 0, "R7 all flushed");

    @(negedge clk);
    fill_en = 1; fill_vpn = 20'h0C0DE; fill_pfn = 20'h0BEEF; fill_attr = 4'h8;
    lk_valid = 1; lk_vpn = 20'h0C0DE;
    @(negedge clk);
    fill_en = 0; lk_valid = 0;
    expect_out(0, 0, 0, "R3 same-cycle lookup misses");
    look(20'h0C0DE, 1, 20'h0BEEF, 4'h8, "R3 fill visible next cycle");

    @(negedge clk);
    inv_pg = 1; inv_vpn = 20'h0C0DE; lk_valid = 1; lk_vpn = 20'h0C0DE;
    @(negedge clk);
    inv_pg = 0; lk_valid = 0;
    expect_out(0, 0, 0, "R9 invalidate before lookup");

    fill(20'h00777, 20'h00888, 4'h3);
    @(negedge clk);
    base_wr = 1; glob_en = 1; lk_valid = 1; lk_vpn = 20'h00777;
    @(negedge clk);
    base_wr = 0; lk_valid = 0;
    expect_out(0, 0, 0, "R9 base write before lookup");

    report();
  end
endmodule